// File: doc/BRIEF.md
# Automatic Remote-Request Response Unit

This unit sits beside a bank of six message buffers inside a CAN-style controller. It answers remote transmission requests without software help. Each buffer carries two configuration bits: a transmit-direction bit and an auto-reply enable bit. A small table maps each acceptance filter to one buffer, or to no buffer. A filter hit stream reports matched frames. A remote frame that hits a filter tied to a qualified buffer makes the unit raise that buffer's pending-transmit flag in hardware, so the data already held in the buffer goes out as the reply.

The unit also holds the buffer contents and guards them. While a buffer is pending, every host write to its data or identifier bytes is dropped, and a one-cycle ignore pulse reports the rejected write. The transmit engine clears a pending flag by reporting completion on a done stream. The host can also raise a flag directly. Automatic replies happen only in operating modes 1 and 2.

The hit, write and done inputs are valid/ready streams. Each ready output goes high in the first cycle after reset is released and stays high. The unit never applies back-pressure, so a transfer happens on every clock edge where valid and ready are both high. Valid is ignored while ready is low. The configuration, mode, request, read and status pins are plain signals.

Top module: `arr_unit`

## Requirements
- R1: During reset and right after it, `pending`, `auto_fire` and `wr_ignored` are zero and every stored byte reads 0. `hit_ready`, `wr_ready` and `done_ready` are low in reset and high from the first cycle after reset is released.
- R2: An accepted hit must meet all of these conditions:
  - `hit_rtr`=1.
  - The filter's map entry is valid.
  - The entry names a buffer index below 6.
  - That buffer has both its transmit bit and its enable bit set.
  - `op_mode` is 1 or 2.
  Such a hit makes `auto_fire` a one-hot pulse for that buffer in the cycle after the accepting edge. The buffer's `pending` bit is set from that same cycle.
- R3: With `op_mode` 0 or 3, no hit ever produces an automatic reply.
- R4: A buffer whose transmit bit or enable bit is clear never replies automatically.
- R5: No reply results in any of these cases: a hit with `hit_rtr`=0, a hit on a filter whose map entry is invalid, or a map entry naming buffer 6 or 7. Several filters may map to the same buffer.
- R6: A write accepted while the target buffer is pending is dropped. The stored byte keeps its old value, and `wr_ignored` is high for exactly the cycle after the accepting edge. A write to a buffer that is not pending updates the byte, and `rd_data` shows the new value from the next cycle. `wr_byte` 0 to 7 select data bytes and 8 to 9 select identifier bytes.
- R7: A qualifying hit on a buffer that is already pending gives no `auto_fire` pulse and leaves the buffer pending. A qualifying hit accepted on the same edge as a done report for that buffer gives no pulse, and the buffer ends up not pending.
- R8: The reply data is the buffer content at the moment of the request. A write accepted on the same edge as a qualifying hit to the same buffer still lands, and the lock starts in the next cycle.
- R9: An accepted done report (`done_valid`, `done_buf`) clears that buffer's `pending` bit from the next cycle. Writes to that buffer are then accepted again.
- R10: A `host_txreq` bit sets the matching `pending` bit in any mode, with no `auto_fire` pulse. A buffer pending this way is write-locked like any other pending buffer.
- R11: Configuration uses `cfg_we` with `cfg_sel`:
  - `cfg_sel`=0 writes buffer `cfg_idx`: bit 0 of `cfg_data` is the transmit bit and bit 1 is the enable bit.
  - `cfg_sel`=1 writes the map entry of filter `cfg_idx`: bit 3 is the valid bit and bits 2:0 are the buffer index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode | input | 2 | Controller operating mode; auto replies only in 1 and 2 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects buffer config, 1 selects filter map entry |
| cfg_idx | input | 4 | Buffer or filter index for the configuration write |
| cfg_data | input | 4 | Configuration value |
| hit_valid | input | 1 | Filter hit valid |
| hit_ready | output | 1 | Filter hit ready |
| hit_filter | input | 4 | Index of the filter that matched |
| hit_rtr | input | 1 | Matched frame is a remote request |
| wr_valid | input | 1 | Host buffer write valid |
| wr_ready | output | 1 | Host buffer write ready |
| wr_buf | input | 3 | Target buffer |
| wr_byte | input | 4 | Byte select (0-7 data, 8-9 identifier) |
| wr_data | input | 8 | Write data |
| wr_ignored | output | 1 | Pulse: previous accepted write was dropped |
| host_txreq | input | 6 | Per-buffer host request to set pending |
| done_valid | input | 1 | Transmit completion valid |
| done_ready | output | 1 | Transmit completion ready |
| done_buf | input | 3 | Buffer whose transmission completed |
| rd_buf | input | 3 | Read buffer select |
| rd_byte | input | 4 | Read byte select |
| rd_data | output | 8 | Stored byte at the read select |
| pending | output | 6 | Per-buffer pending-transmit flags |
| auto_fire | output | 6 | One-cycle pulse per automatically queued reply |

## Verification
The hardest situations to reach are the collisions at a single edge. One is a qualifying remote hit landing on the same edge as a host write to that buffer. Another is the same hit landing on the same edge as a completion report for it. Both decide whether data lands and whether a second reply is queued. The bench reaches them by driving both streams in the same cycle, with the buffer prepared beforehand into a known pending or idle state. It then reads the stored byte back and watches the pulse and flag outputs one cycle later.

// File: rtl/arr_pkg.sv
package arr_pkg;
  localparam int BUF_IDX_W  = 3;
  localparam int CFG_DATA_W = 4;
  localparam int BYTE_SEL_W = 4;

  typedef enum logic { CFG_BUF = 1'b0, CFG_MAP = 1'b1 } cfg_sel_e;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_ENH    = 2'd1,
    MODE_FIFO   = 2'd2,
    MODE_RSVD   = 2'd3
  } op_mode_e;

  typedef struct packed {
    logic                 vld;
    logic [BUF_IDX_W-1:0] idx;
  } map_entry_t;

  function automatic logic mode_allows_reply(input logic [1:0] m);
    return (m == MODE_ENH) || (m == MODE_FIFO);
  endfunction
endpackage

// File: rtl/arr_cfg_regs.sv
module arr_cfg_regs
  import arr_pkg::*;
#(
  parameter int NBUF  = 6,
  parameter int NFILT = 16,
  parameter int FW    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_sel,
  input  logic [FW-1:0]         cfg_idx,
  input  logic [CFG_DATA_W-1:0] cfg_data,
  output logic [NBUF-1:0]       buf_tx,
  output logic [NBUF-1:0]       buf_en,
  output map_entry_t            map_tab [NFILT]
);
  // Per-buffer direction and enable bits
  for (genvar b = 0; b < NBUF; b++) begin : g_bcfg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        buf_tx[b] <= 1'b0;
        buf_en[b] <= 1'b0;
      end else if (cfg_we && cfg_sel == CFG_BUF && cfg_idx == FW'(b)) begin
        buf_tx[b] <= cfg_data[0];
        buf_en[b] <= cfg_data[1];
      end
    end
  end

  // Filter-to-buffer association table
  for (genvar f = 0; f < NFILT; f++) begin : g_map
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        map_tab[f] <= '0;
      end else if (cfg_we && cfg_sel == CFG_MAP && cfg_idx == FW'(f)) begin
        map_tab[f].vld <= cfg_data[3];
        map_tab[f].idx <= cfg_data[BUF_IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/arr_hit_decode.sv
module arr_hit_decode
  import arr_pkg::*;
#(
  parameter int NBUF  = 6,
  parameter int NFILT = 16,
  parameter int FW    = 4
) (
  input  logic             hit_take,
  input  logic             hit_rtr,
  input  logic [FW-1:0]    hit_filter,
  input  logic [1:0]       op_mode,
  input  logic [NBUF-1:0]  buf_tx,
  input  logic [NBUF-1:0]  buf_en,
  input  map_entry_t       map_tab [NFILT],
  output logic [NBUF-1:0]  qual
);
  map_entry_t ent;
  logic       gate;

  always_comb begin
    ent = '0;
    for (int f = 0; f < NFILT; f++) begin
      if (hit_filter == FW'(f)) ent = map_tab[f];
    end
  end

  assign gate = hit_take && hit_rtr && ent.vld && mode_allows_reply(op_mode);

  for (genvar b = 0; b < NBUF; b++) begin : g_qual
    assign qual[b] = gate && (ent.idx == BUF_IDX_W'(b)) && buf_tx[b] && buf_en[b];
  end
endmodule

// File: rtl/arr_req_flags.sv
module arr_req_flags
  import arr_pkg::*;
#(
  parameter int NBUF = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NBUF-1:0]      qual,
  input  logic [NBUF-1:0]      host_set,
  input  logic                 done_take,
  input  logic [BUF_IDX_W-1:0] done_buf,
  output logic [NBUF-1:0]      pending,
  output logic [NBUF-1:0]      fire_q
);
  logic [NBUF-1:0] done_vec;
  logic [NBUF-1:0] fire_d;

  for (genvar b = 0; b < NBUF; b++) begin : g_flag
    assign done_vec[b] = done_take && (done_buf == BUF_IDX_W'(b));
    // No fresh request for a buffer that is already pending
    assign fire_d[b]   = qual[b] && !pending[b];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending[b] <= 1'b0;
        fire_q[b]  <= 1'b0;
      end else begin
        fire_q[b]  <= fire_d[b];
        pending[b] <= (pending[b] && !done_vec[b]) || fire_d[b] || host_set[b];
      end
    end
  end

  a_r2_onehot_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_q));
  a_r2_fire_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire_q) |-> ((fire_q & pending) == fire_q));
  a_r7_no_requeue: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire_q) |-> ((fire_q & $past(pending)) == '0));
endmodule

// File: rtl/arr_buf_bank.sv
module arr_buf_bank
  import arr_pkg::*;
#(
  parameter int NBUF  = 6,
  parameter int BYTES = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_take,
  input  logic [BUF_IDX_W-1:0]  wr_buf,
  input  logic [BYTE_SEL_W-1:0] wr_byte,
  input  logic [7:0]            wr_data,
  input  logic [NBUF-1:0]       pending,
  input  logic [BUF_IDX_W-1:0]  rd_buf,
  input  logic [BYTE_SEL_W-1:0] rd_byte,
  output logic [7:0]            rd_data,
  output logic                  wr_ignored
);
  logic [7:0]      mem [NBUF][BYTES];
  logic [NBUF-1:0] tgt;
  logic            locked_hit;

  for (genvar b = 0; b < NBUF; b++) begin : g_row
    assign tgt[b] = wr_take && (wr_buf == BUF_IDX_W'(b));
    for (genvar k = 0; k < BYTES; k++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n) mem[b][k] <= 8'h00;
        else if (tgt[b] && !pending[b] && wr_byte == BYTE_SEL_W'(k)) mem[b][k] <= wr_data;
      end
    end
  end

  assign locked_hit = |(tgt & pending);

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ignored <= 1'b0;
    else        wr_ignored <= locked_hit;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int b = 0; b < NBUF; b++) begin
      for (int k = 0; k < BYTES; k++) begin
        if (rd_buf == BUF_IDX_W'(b) && rd_byte == BYTE_SEL_W'(k)) rd_data = mem[b][k];
      end
    end
  end

  a_r6_ignore_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |-> ($past(wr_take) && ($past(pending & tgt) != '0)));
endmodule

// File: rtl/arr_unit.sv
module arr_unit
  import arr_pkg::*;
#(
  parameter int NBUF  = 6,
  parameter int NFILT = 16,
  parameter int BYTES = 10,
  localparam int FW   = $clog2(NFILT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            op_mode,
  input  logic                  cfg_we,
  input  logic                  cfg_sel,
  input  logic [FW-1:0]         cfg_idx,
  input  logic [CFG_DATA_W-1:0] cfg_data,
  input  logic                  hit_valid,
  output logic                  hit_ready,
  input  logic [FW-1:0]         hit_filter,
  input  logic                  hit_rtr,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [BUF_IDX_W-1:0]  wr_buf,
  input  logic [BYTE_SEL_W-1:0] wr_byte,
  input  logic [7:0]            wr_data,
  output logic                  wr_ignored,
  input  logic [NBUF-1:0]       host_txreq,
  input  logic                  done_valid,
  output logic                  done_ready,
  input  logic [BUF_IDX_W-1:0]  done_buf,
  input  logic [BUF_IDX_W-1:0]  rd_buf,
  input  logic [BYTE_SEL_W-1:0] rd_byte,
  output logic [7:0]            rd_data,
  output logic [NBUF-1:0]       pending,
  output logic [NBUF-1:0]       auto_fire
);
  logic            up_q;
  logic [NBUF-1:0] buf_tx, buf_en, qual;
  map_entry_t      map_tab [NFILT];

  always_ff @(posedge clk) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  assign hit_ready  = up_q;
  assign wr_ready   = up_q;
  assign done_ready = up_q;

  arr_cfg_regs #(.NBUF(NBUF), .NFILT(NFILT), .FW(FW)) cfg_i (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_idx, .cfg_data,
    .buf_tx, .buf_en, .map_tab
  );

  arr_hit_decode #(.NBUF(NBUF), .NFILT(NFILT), .FW(FW)) dec_i (
    .hit_take(hit_valid && up_q), .hit_rtr, .hit_filter, .op_mode,
    .buf_tx, .buf_en, .map_tab, .qual
  );

  arr_req_flags #(.NBUF(NBUF)) flg_i (
    .clk, .rst_n, .qual, .host_set(host_txreq & {NBUF{up_q}}),
    .done_take(done_valid && up_q), .done_buf, .pending, .fire_q(auto_fire)
  );

  arr_buf_bank #(.NBUF(NBUF), .BYTES(BYTES)) bank_i (
    .clk, .rst_n, .wr_take(wr_valid && up_q), .wr_buf, .wr_byte, .wr_data,
    .pending, .rd_buf, .rd_byte, .rd_data, .wr_ignored
  );

  a_r3_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (|auto_fire) |-> ($past(op_mode) == MODE_ENH || $past(op_mode) == MODE_FIFO));
  a_r5_fire_needs_rtr: assert property (@(posedge clk) disable iff (!rst_n)
    (|auto_fire) |-> ($past(hit_valid) && $past(hit_rtr)));
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (hit_ready && wr_ready && done_ready));
endmodule

// File: tb/arr_unit_tb.sv
module arr_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] op_mode = 2'd1;
  logic cfg_we = 0, cfg_sel = 0;
  logic [3:0] cfg_idx = 0, cfg_data = 0;
  logic hit_valid = 0, hit_rtr = 0;
  logic [3:0] hit_filter = 0;
  logic hit_ready, wr_ready, done_ready, wr_ignored;
  logic wr_valid = 0;
  logic [2:0] wr_buf = 0, done_buf = 0, rd_buf = 0;
  logic [3:0] wr_byte = 0, rd_byte = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [5:0] host_txreq = 0, pending, auto_fire;
  logic done_valid = 0;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  arr_unit dut_i (
    .clk, .rst_n, .op_mode, .cfg_we, .cfg_sel, .cfg_idx, .cfg_data,
    .hit_valid, .hit_ready, .hit_filter, .hit_rtr,
    .wr_valid, .wr_ready, .wr_buf, .wr_byte, .wr_data, .wr_ignored,
    .host_txreq, .done_valid, .done_ready, .done_buf,
    .rd_buf, .rd_byte, .rd_data, .pending, .auto_fire
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic sel, input logic [3:0] idx, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_all();
    for (int b = 0; b < 6; b++) begin
      if (pending[b]) begin
        done_valid = 1; done_buf = 3'(b);
        @(negedge clk);
        done_valid = 0;
      end
    end
  endtask

  task automatic rd(input logic [2:0] b, input logic [3:0] k);
    rd_buf = b; rd_byte = k; #1;
  endtask

  // {mode[1:0], filter[3:0], rtr, expected auto_fire[5:0]}
  localparam logic [12:0] VEC [0:10] = '{
    {2'd1, 4'd0, 1'b1, 6'b000001},  // R2 mapped, tx+en
    {2'd1, 4'd0, 1'b0, 6'b000000},  // R5 data frame
    {2'd1, 4'd1, 1'b1, 6'b000000},  // R4 enable clear
    {2'd1, 4'd2, 1'b1, 6'b000000},  // R4 tx clear
    {2'd2, 4'd3, 1'b1, 6'b001000},  // R2 mode 2
    {2'd1, 4'd4, 1'b1, 6'b000000},  // R5 invalid entry
    {2'd1, 4'd5, 1'b1, 6'b000000},  // R5 index 7
    {2'd1, 4'd6, 1'b1, 6'b000001},  // R5 second filter, same buffer
    {2'd0, 4'd7, 1'b1, 6'b000000},  // R3 mode 0
    {2'd3, 4'd7, 1'b1, 6'b000000},  // R3 mode 3
    {2'd1, 4'd7, 1'b1, 6'b010000}   // R2 buffer 4
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pending in reset", pending, 0);
    chk("R1 ready low in reset", {hit_ready, wr_ready, done_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", {hit_ready, wr_ready, done_ready}, 3'b111);
    chk("R1 auto_fire idle", {auto_fire, wr_ignored}, 0);
    rd(3'd3, 4'd9);
    chk("R1 storage cleared", rd_data, 0);

    // R11 configuration: bit0 tx, bit1 enable; map bit3 valid, bits2:0 buffer
    cfg(0, 0, 4'b0011); cfg(0, 1, 4'b0001); cfg(0, 2, 4'b0010);
    cfg(0, 3, 4'b0011); cfg(0, 4, 4'b0011);
    cfg(1, 0, 4'b1000); cfg(1, 1, 4'b1001); cfg(1, 2, 4'b1010);
    cfg(1, 3, 4'b1011); cfg(1, 4, 4'b0011); cfg(1, 5, 4'b1111);
    cfg(1, 6, 4'b1000); cfg(1, 7, 4'b1100);

    for (int v = 0; v < 11; v++) begin
      op_mode = VEC[v][12:11]; hit_filter = VEC[v][10:7]; hit_rtr = VEC[v][6];
      hit_valid = 1;
      @(negedge clk);
      hit_valid = 0;
      chk($sformatf("R2 R3 R4 R5 R11 vector %0d auto_fire", v), auto_fire, VEC[v][5:0]);
      chk($sformatf("R2 vector %0d pending", v), pending, VEC[v][5:0]);
      clear_all();
      chk($sformatf("R9 vector %0d cleared", v), pending, 0);
    end
    op_mode = 2'd1;

    // R6 write to idle buffer lands
    wr_valid = 1; wr_buf = 0; wr_byte = 2; wr_data = 8'hAA;
    @(negedge clk);
    wr_valid = 0;
    chk("R6 idle write not ignored", wr_ignored, 0);
    rd(3'd0, 4'd2);
    chk("R6 idle write lands", rd_data, 8'hAA);

    // R8 write and hit on the same edge: write lands, lock follows
    hit_valid = 1; hit_filter = 0; hit_rtr = 1;
    wr_valid = 1; wr_buf = 0; wr_byte = 8; wr_data = 8'h3C;
    @(negedge clk);
    hit_valid = 0; wr_valid = 0;
    chk("R8 same-edge write not ignored", wr_ignored, 0);
    chk("R8 hit pulses", auto_fire, 6'b000001);
    rd(3'd0, 4'd8);
    chk("R8 same-edge id byte lands", rd_data, 8'h3C);

    // R6 locked write dropped
    wr_valid = 1; wr_buf = 0; wr_byte = 2; wr_data = 8'h55;
    @(negedge clk);
    wr_valid = 0;
    chk("R6 locked write pulse", wr_ignored, 1);
    rd(3'd0, 4'd2);
    chk("R6 locked byte unchanged", rd_data, 8'hAA);
    @(negedge clk);
    chk("R6 pulse one cycle", wr_ignored, 0);

    // R7 repeated hit while pending
    hit_valid = 1;
    @(negedge clk);
    hit_valid = 0;
    chk("R7 no requeue pulse", auto_fire, 0);
    chk("R7 still pending", pending, 6'b000001);

    // R7 hit with done on the same edge
    hit_valid = 1; done_valid = 1; done_buf = 0;
    @(negedge clk);
    hit_valid = 0; done_valid = 0;
    chk("R7 hit+done no pulse", auto_fire, 0);
    chk("R7 hit+done clears", pending, 0);

    // R9 write accepted again after completion
    wr_valid = 1; wr_buf = 0; wr_byte = 2; wr_data = 8'h77;
    @(negedge clk);
    wr_valid = 0;
    rd(3'd0, 4'd2);
    chk("R9 write after done", {wr_ignored, rd_data}, {1'b0, 8'h77});

    // R10 host request in mode 0 locks buffer 5 without a pulse
    op_mode = 2'd0;
    host_txreq = 6'b100000;
    @(negedge clk);
    host_txreq = 0;
    chk("R10 host set pending", pending, 6'b100000);
    chk("R10 no auto pulse", auto_fire, 0);
    wr_valid = 1; wr_buf = 5; wr_byte = 1; wr_data = 8'h99;
    @(negedge clk);
    wr_valid = 0;
    rd(3'd5, 4'd1);
    chk("R10 host pending locks", {wr_ignored, rd_data}, {1'b1, 8'h00});
    clear_all();
    chk("R9 host pending cleared", pending, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule